// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This unit holds the privileged state of a small in-order core: the status word, the cause word, the saved exception PC, the faulting address, the exception vector base, a count/compare timer and a free-running retired-instruction counter. Each cycle it decides whether the core must leave its instruction stream. A trap can come from a synchronous exception request raised by the pipeline. It can also come from an interrupt line whose pending bit is set, whose mask bit is set and whose global trap-enable is on. When the unit takes a trap, it gives the core a redirect PC and a one-cycle strobe.

Exception requests, the current PC and the faulting address pass through a single register stage. A request seen at one clock edge therefore produces its redirect at the next edge. The inter-processor interrupt pulse and the timer set their own pending bits in the cause word. The IPI also raises a run flag that stays high. Status writes are cleaned on the way in: reserved bits and bits for features the build leaves out always read as zero.

Top module: `trapctl_unit`

## Requirements
- R1: After reset, redirect PC, vector base, EPC, bad address, cause, count, compare, the instruction counter, run flag, trap strobe and error strobe are all zero. The status word holds only the supervisor bit (bit 5) and the supervisor-64 bit (bit 7), giving 0x0000A0.
- R2: Status layout: bit 0 global enable, bit 1 FPU enable, bit 2 vector enable, bit 3 compressed enable, bit 4 previous supervisor, bit 5 supervisor, bit 6 user-64, bit 7 supervisor-64, bits 15:8 reserved, and bits 16 and up the per-line interrupt mask. Reserved bits read zero after any write. So do the bits of features that are not configured (FPU, vector or compressed enable, or both 64-bit bits).
- R3: An exception request sampled at clock edge k, with global enable set and no enabled interrupt, produces a one-cycle trap strobe after edge k+1. In that same cycle the redirect PC equals the vector base, the EPC equals the sampled PC, and the bad address equals the sampled fault address.
- R4: Taking a trap clears the global enable, sets the supervisor bit, and copies the old supervisor bit into the previous-supervisor bit. All other status bits stay as they were.
- R5: Cause layout: the trap code sits in bits CODE_W-1:0 and the pending bits in bits 8 and up. A trap overwrites the code and keeps every pending bit.
- R6: An exception request sampled while the global enable is clear gives a one-cycle error strobe at edge k+1 and no trap. EPC, bad address, cause and status stay unchanged.
- R7: An interrupt is taken when the pending bits ANDed with the mask field are nonzero and the global enable is set. It is not taken when either condition is missing. An interrupt trap writes code IRQ_CODE (0x1F), saves the registered current PC to EPC, and leaves the bad address unchanged.
- R8: When an exception request and an enabled interrupt fall in the same decision cycle, the interrupt is taken and the exception request is dropped. Exactly one trap results.
- R9: An IPI pulse sets pending bit IPI_LINE at the next edge and sets the run flag, which then stays high.
- R10: Count and the instruction counter each advance by the retired-instruction increment every cycle.
- R11: The timer pending bit (TIMER_LINE) is set when the old count is below compare and the new count is at least compare.
- R12: The timer pending bit is also set when the old count is below compare and the increment wraps the count past its maximum. It is not set when the old count is already at or above compare.
- R13: A compare write clears the timer pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Trap code of the request |
| pc_i | input | PC_W | PC of the instruction now in the pipeline |
| exc_addr | input | PC_W | Faulting address of the request |
| ipi_pulse | input | 1 | Inter-processor interrupt pulse |
| retire_inc | input | INC_W | Instructions retired this cycle |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 16+NUM_IRQ | Status write data |
| cmp_we | input | 1 | Compare write enable |
| cmp_wdata | input | COUNT_W | Compare write data |
| evec_we | input | 1 | Vector base write enable |
| evec_wdata | input | PC_W | Vector base write data |
| trap_taken | output | 1 | One-cycle trap strobe |
| fatal_err | output | 1 | Trap requested with global enable clear |
| redirect_pc | output | PC_W | Target PC of the last trap |
| status_o | output | 16+NUM_IRQ | Status word |
| cause_o | output | 8+NUM_IRQ | Cause word (code and pending bits) |
| epc_o | output | PC_W | Saved exception PC |
| badaddr_o | output | PC_W | Saved faulting address |
| count_o | output | COUNT_W | Timer count |
| cycles_o | output | CYC_W | Retired-instruction counter |
| run_o | output | 1 | Core run flag |

## Verification
The wrap-around timer crossing is the hardest case to reach: the count can only move forward, so it cannot be loaded near its limit. The bench builds the unit with an 8-bit count. It sets compare to the maximum value and climbs with fifteen increments of 15 to 250. One increment of 10 then wraps the count to 4, and the check is that the timer pending bit is set anyway. The interrupt-over-exception tie is reached by writing a status word that unmasks an already pending IPI at the same edge that samples an exception request.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;
  // status word bit positions
  localparam int ST_EN   = 0;
  localparam int ST_FPU  = 1;
  localparam int ST_VEC  = 2;
  localparam int ST_CMP  = 3;
  localparam int ST_PSUP = 4;
  localparam int ST_SUP  = 5;
  localparam int ST_U64  = 6;
  localparam int ST_S64  = 7;
  localparam int ST_MASK_LO  = 16;
  // cause word: pending field start
  localparam int CA_PEND_LO = 8;
endpackage

// File: rtl/tc_req_stage.sv
module tc_req_stage #(
  parameter int PC_W   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   addr_i,
  output logic              req_q,
  output logic [CODE_W-1:0] code_q,
  output logic [PC_W-1:0]   pc_q,
  output logic [PC_W-1:0]   addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      code_q <= '0;
      pc_q   <= '0;
      addr_q <= '0;
    end else begin
      req_q  <= req_i;
      code_q <= code_i;
      pc_q   <= pc_i;
      addr_q <= addr_i;
    end
  end
endmodule

// File: rtl/tc_status.sv
module tc_status
  import trapctl_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter bit HAS_FPU = 1'b0,
  parameter bit HAS_VEC = 1'b0,
  parameter bit HAS_CMP = 1'b1,
  parameter bit HAS_64  = 1'b1,
  localparam int ST_W   = ST_MASK_LO + NUM_IRQ
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [ST_W-1:0] wdata,
  input  logic            trap_take,
  output logic [ST_W-1:0] status_q
);
  localparam logic [7:0] LOW_KEEP = {HAS_64, HAS_64, 1'b1, 1'b1,
                                     HAS_CMP, HAS_VEC, HAS_FPU, 1'b1};
  localparam logic [ST_W-1:0] KEEP = {{NUM_IRQ{1'b1}}, 8'h00, LOW_KEEP};
  localparam logic [ST_W-1:0] RST_VAL =
    ((ST_W'(1) << ST_SUP) | (ST_W'(1) << ST_S64)) & KEEP;

  logic [ST_W-1:0] trap_val;

  always_comb begin
    trap_val          = status_q;
    trap_val[ST_EN]   = 1'b0;
    trap_val[ST_PSUP] = status_q[ST_SUP];
    trap_val[ST_SUP]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            status_q <= RST_VAL;
    else if (trap_take) status_q <= trap_val;
    else if (we)        status_q <= wdata & KEEP;
  end
endmodule

// File: rtl/tc_timer.sv
module tc_timer #(
  parameter int COUNT_W = 32,
  parameter int INC_W   = 4,
  parameter int CYC_W   = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INC_W-1:0]   inc,
  input  logic               cmp_we,
  input  logic [COUNT_W-1:0] cmp_wdata,
  output logic [COUNT_W-1:0] count_q,
  output logic [CYC_W-1:0]   cycles_q,
  output logic               hit
);
  logic [COUNT_W-1:0] cmp_q;
  logic [COUNT_W:0]   sum;

  assign sum = {1'b0, count_q} + (COUNT_W+1)'(inc);
  // crossing: started below compare and reached it, or wrapped past the top
  assign hit = (count_q < cmp_q) &&
               (sum[COUNT_W] || (sum[COUNT_W-1:0] >= cmp_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      cmp_q    <= '0;
      cycles_q <= '0;
    end else begin
      count_q  <= sum[COUNT_W-1:0];
      cycles_q <= cycles_q + CYC_W'(inc);
      if (cmp_we) cmp_q <= cmp_wdata;
    end
  end
endmodule

// File: rtl/trapctl_unit.sv
module trapctl_unit
  import trapctl_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int CODE_W     = 5,
  parameter int NUM_IRQ    = 8,
  parameter int TIMER_LINE = 7,
  parameter int IPI_LINE   = 6,
  parameter int COUNT_W    = 32,
  parameter int INC_W      = 4,
  parameter int CYC_W      = 48,
  parameter logic [CODE_W-1:0] IRQ_CODE = '1,
  parameter bit HAS_FPU    = 1'b0,
  parameter bit HAS_VEC    = 1'b0,
  parameter bit HAS_CMP    = 1'b1,
  parameter bit HAS_64     = 1'b1,
  localparam int ST_W      = ST_MASK_LO + NUM_IRQ,
  localparam int CA_W      = CA_PEND_LO + NUM_IRQ
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_req,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    exc_addr,
  input  logic               ipi_pulse,
  input  logic [INC_W-1:0]   retire_inc,
  input  logic               stat_we,
  input  logic [ST_W-1:0]    stat_wdata,
  input  logic               cmp_we,
  input  logic [COUNT_W-1:0] cmp_wdata,
  input  logic               evec_we,
  input  logic [PC_W-1:0]    evec_wdata,
  output logic               trap_taken,
  output logic               fatal_err,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [ST_W-1:0]    status_o,
  output logic [CA_W-1:0]    cause_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [PC_W-1:0]    badaddr_o,
  output logic [COUNT_W-1:0] count_o,
  output logic [CYC_W-1:0]   cycles_o,
  output logic               run_o
);
  logic              req_q;
  logic [CODE_W-1:0] code_q;
  logic [PC_W-1:0]   pc_q, addr_q;
  logic [PC_W-1:0]   evec_q;
  logic [NUM_IRQ-1:0] pend_q, pend_n;
  logic [CODE_W-1:0] ccode_q;
  logic              tmr_hit;
  logic              irq_fire, exc_fire, trap_now, fatal_now;

  tc_req_stage #(.PC_W(PC_W), .CODE_W(CODE_W)) u_req (
    .clk(clk), .rst(rst), .req_i(exc_req), .code_i(exc_code),
    .pc_i(pc_i), .addr_i(exc_addr),
    .req_q(req_q), .code_q(code_q), .pc_q(pc_q), .addr_q(addr_q)
  );

  tc_status #(.NUM_IRQ(NUM_IRQ), .HAS_FPU(HAS_FPU), .HAS_VEC(HAS_VEC),
              .HAS_CMP(HAS_CMP), .HAS_64(HAS_64)) u_stat (
    .clk(clk), .rst(rst), .we(stat_we), .wdata(stat_wdata),
    .trap_take(trap_now), .status_q(status_o)
  );

  tc_timer #(.COUNT_W(COUNT_W), .INC_W(INC_W), .CYC_W(CYC_W)) u_tmr (
    .clk(clk), .rst(rst), .inc(retire_inc), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .count_q(count_o), .cycles_q(cycles_o),
    .hit(tmr_hit)
  );

  // trap decision from registered request and current state
  assign irq_fire  = status_o[ST_EN] &&
                     |(pend_q & status_o[ST_MASK_LO +: NUM_IRQ]);
  assign exc_fire  = req_q && status_o[ST_EN] && !irq_fire;
  assign fatal_now = req_q && !status_o[ST_EN];
  assign trap_now  = irq_fire || exc_fire;

  always_comb begin
    pend_n = pend_q;
    if (ipi_pulse) pend_n[IPI_LINE] = 1'b1;
    if (tmr_hit)   pend_n[TIMER_LINE] = 1'b1;
    if (cmp_we)    pend_n[TIMER_LINE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      ccode_q     <= '0;
      evec_q      <= '0;
      epc_o       <= '0;
      badaddr_o   <= '0;
      redirect_pc <= '0;
      trap_taken  <= 1'b0;
      fatal_err   <= 1'b0;
      run_o       <= 1'b0;
    end else begin
      pend_q     <= pend_n;
      trap_taken <= trap_now;
      fatal_err  <= fatal_now;
      if (ipi_pulse) run_o  <= 1'b1;
      if (evec_we)   evec_q <= evec_wdata;
      if (trap_now) begin
        ccode_q     <= irq_fire ? IRQ_CODE : code_q;
        epc_o       <= pc_q;
        redirect_pc <= evec_q;
        if (exc_fire) badaddr_o <= addr_q;
      end
    end
  end

  always_comb begin
    cause_o = '0;
    cause_o[CODE_W-1:0] = ccode_q;
    cause_o[CA_PEND_LO +: NUM_IRQ] = pend_q;
  end
endmodule

// File: rtl/trapctl_unit_chk.sv
module trapctl_unit_chk
  import trapctl_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int NUM_IRQ    = 8,
  parameter int TIMER_LINE = 7,
  localparam int ST_W      = ST_MASK_LO + NUM_IRQ,
  localparam int CA_W      = CA_PEND_LO + NUM_IRQ
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_taken,
  input logic            fatal_err,
  input logic [ST_W-1:0] status_o,
  input logic [CA_W-1:0] cause_o,
  input logic [PC_W-1:0] epc_o,
  input logic            run_o
);
  logic [NUM_IRQ-1:0] keep_pend;
  always_comb begin
    keep_pend = cause_o[CA_PEND_LO +: NUM_IRQ];
    keep_pend[TIMER_LINE] = 1'b0;
  end

  // R4
  trap_status_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> (!status_o[ST_EN] && status_o[ST_SUP]));
  // R4
  trap_prev_sup_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> (status_o[ST_PSUP] == $past(status_o[ST_SUP])));
  // R5
  trap_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken |-> ((keep_pend & $past(keep_pend)) == $past(keep_pend)));
  // R6
  fatal_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    fatal_err |-> !trap_taken);
  // R6
  fatal_epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fatal_err |-> $stable(epc_o));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status_o[15:8] == 8'h00);
  // R9
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    run_o |=> run_o);
endmodule

bind trapctl_unit trapctl_unit_chk #(
  .PC_W(PC_W), .NUM_IRQ(NUM_IRQ), .TIMER_LINE(TIMER_LINE)
) u_chk (
  .clk(clk), .rst(rst), .trap_taken(trap_taken), .fatal_err(fatal_err),
  .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o), .run_o(run_o)
);

// File: tb/trapctl_unit_bench.sv
module trapctl_unit_bench;
  localparam int PC_W = 32, CODE_W = 5, NUM_IRQ = 8;
  localparam int COUNT_W = 8, INC_W = 4, CYC_W = 16;
  localparam int ST_W = 16 + NUM_IRQ, CA_W = 8 + NUM_IRQ;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [PC_W-1:0]   epc;
    logic [PC_W-1:0]   target;
    logic [PC_W-1:0]   bad;
  } trap_item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic exc_req = 0, ipi_pulse = 0, stat_we = 0, cmp_we = 0, evec_we = 0;
  logic [CODE_W-1:0] exc_code = '0;
  logic [PC_W-1:0] pc_i = '0, exc_addr = '0, evec_wdata = '0;
  logic [INC_W-1:0] retire_inc = '0;
  logic [ST_W-1:0] stat_wdata = '0;
  logic [COUNT_W-1:0] cmp_wdata = '0;
  logic trap_taken, fatal_err, run_o;
  logic [PC_W-1:0] redirect_pc, epc_o, badaddr_o;
  logic [ST_W-1:0] status_o;
  logic [CA_W-1:0] cause_o;
  logic [COUNT_W-1:0] count_o;
  logic [CYC_W-1:0] cycles_o;

  int total = 0, bad = 0;
  bit done = 0;
  trap_item_t expq[$];

  always #5 clk = ~clk;

  trapctl_unit #(.PC_W(PC_W), .CODE_W(CODE_W), .NUM_IRQ(NUM_IRQ),
    .TIMER_LINE(7), .IPI_LINE(6), .COUNT_W(COUNT_W), .INC_W(INC_W),
    .CYC_W(CYC_W)) u_trapctl_unit (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
    .pc_i(pc_i), .exc_addr(exc_addr), .ipi_pulse(ipi_pulse),
    .retire_inc(retire_inc), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .evec_we(evec_we),
    .evec_wdata(evec_wdata), .trap_taken(trap_taken), .fatal_err(fatal_err),
    .redirect_pc(redirect_pc), .status_o(status_o), .cause_o(cause_o),
    .epc_o(epc_o), .badaddr_o(badaddr_o), .count_o(count_o),
    .cycles_o(cycles_o), .run_o(run_o));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected traps as the strobe appears
  always @(negedge clk) begin
    if (!rst && trap_taken) begin
      if (expq.size() == 0) check("R3 unexpected trap", 1, 0);
      else begin
        trap_item_t e;
        e = expq.pop_front();
        check("R5 trap code", cause_o[CODE_W-1:0], e.code);
        check("R3 epc", epc_o, e.epc);
        check("R3 redirect", redirect_pc, e.target);
        check("R7 badaddr", badaddr_o, e.bad);
      end
    end
  end

  task automatic wstat(logic [ST_W-1:0] v);
    @(negedge clk); stat_we = 1; stat_wdata = v;
    @(negedge clk); stat_we = 0;
  endtask
  task automatic wcmp(logic [COUNT_W-1:0] v);
    @(negedge clk); cmp_we = 1; cmp_wdata = v;
    @(negedge clk); cmp_we = 0;
  endtask
  task automatic bump(logic [INC_W-1:0] n);
    @(negedge clk); retire_inc = n;
    @(negedge clk); retire_inc = 0;
  endtask
  // driver: raise an exception and optionally push the expected trap
  task automatic exc(logic [CODE_W-1:0] c, logic [PC_W-1:0] a,
                     bit expect_trap, logic [PC_W-1:0] target);
    trap_item_t e;
    @(negedge clk); exc_req = 1; exc_code = c; exc_addr = a;
    e.code = c; e.epc = pc_i; e.target = target; e.bad = a;
    if (expect_trap) expq.push_back(e);
    @(negedge clk); exc_req = 0;
    @(negedge clk);
  endtask
  task automatic push_irq(logic [PC_W-1:0] target, logic [PC_W-1:0] b);
    trap_item_t e;
    e.code = 5'h1F; e.epc = pc_i; e.target = target; e.bad = b;
    expq.push_back(e);
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status_o, 24'h0000A0);
    check("R1 cause", cause_o, 0);
    check("R1 epc", epc_o, 0);
    check("R1 badaddr", badaddr_o, 0);
    check("R1 redirect", redirect_pc, 0);
    check("R1 count", count_o, 0);
    check("R1 cycles", cycles_o, 0);
    check("R1 run", run_o, 0);
    check("R1 strobes", {trap_taken, fatal_err}, 0);

    // R6 request while enable is clear
    pc_i = 32'h44;
    exc(5'd7, 32'h99, 0, 0);
    check("R6 fatal strobe", fatal_err, 1);
    check("R6 no trap", trap_taken, 0);
    check("R6 epc", epc_o, 0);
    check("R6 badaddr", badaddr_o, 0);
    check("R6 cause", cause_o, 0);
    check("R6 status", status_o, 24'h0000A0);
    @(negedge clk);
    check("R6 strobe one cycle", fatal_err, 0);

    // R2 sanitizing
    wstat(24'hFFFFFF);
    check("R2 all ones", status_o, 24'hFF00F9);
    wstat(24'h000021);
    check("R2 plain", status_o, 24'h000021);

    @(negedge clk); evec_we = 1; evec_wdata = 32'h100;
    @(negedge clk); evec_we = 0;

    // R3 / R4 / R5 exception from supervisor
    pc_i = 32'h40;
    exc(5'd3, 32'hDEAD, 1, 32'h100);
    check("R3 strobe", trap_taken, 1);
    check("R4 status sup", status_o, 24'h000030);
    @(negedge clk);
    check("R3 strobe one cycle", trap_taken, 0);

    // R4 from user mode
    wstat(24'h000001);
    pc_i = 32'h60;
    exc(5'd2, 32'hBEEF, 1, 32'h100);
    check("R4 status user", status_o, 24'h000020);
    check("R5 cause code", cause_o, 16'h0002);

    // R9 IPI
    @(negedge clk); ipi_pulse = 1;
    @(negedge clk); ipi_pulse = 0;
    check("R9 pending", cause_o, 16'h4002);
    check("R9 run", run_o, 1);

    // R7 gating
    pc_i = 32'h80;
    wstat(24'h000021);
    idle(3);
    check("R7 masked no trap", expq.size() + int'(status_o[0]), 1);
    wstat(24'h400020);
    idle(3);
    check("R7 disabled no trap", status_o, 24'h400020);
    push_irq(32'h100, 32'hBEEF);
    wstat(24'h400021);
    idle(2);
    check("R7 irq taken", expq.size(), 0);
    check("R5 pend kept", cause_o, 16'h401F);
    check("R7 status", status_o, 24'h400030);

    // R8 interrupt wins over a same-cycle exception
    push_irq(32'h100, 32'hBEEF);
    @(negedge clk); stat_we = 1; stat_wdata = 24'h400021;
    exc_req = 1; exc_code = 5'd4; exc_addr = 32'h1234;
    @(negedge clk); stat_we = 0; exc_req = 0;
    idle(4);
    check("R8 single trap", expq.size(), 0);
    check("R8 badaddr kept", badaddr_o, 32'hBEEF);
    check("R8 code", cause_o[4:0], 5'h1F);

    // R10 / R11 timer
    wstat(24'h800021);
    wcmp(8'd20);
    bump(4'd15);
    check("R10 count", count_o, 15);
    check("R10 cycles", cycles_o, 15);
    check("R11 not yet", cause_o[15], 0);
    push_irq(32'h100, 32'hBEEF);
    bump(4'd10);
    check("R11 pending", cause_o[15], 1);
    idle(2);
    check("R11 timer trap", expq.size(), 0);
    check("R11 cause", cause_o, 16'hC01F);

    // R13 compare write clears
    wcmp(8'd200);
    check("R13 cleared", cause_o, 16'h401F);

    // R12 wrap crossing
    wcmp(8'd255);
    for (int i = 0; i < 15; i++) bump(4'd15);
    check("R12 count before wrap", count_o, 250);
    check("R12 no early set", cause_o[15], 0);
    bump(4'd10);
    check("R12 wrapped count", count_o, 4);
    check("R12 wrap sets", cause_o[15], 1);
    wcmp(8'd3);
    check("R13 clear again", cause_o[15], 0);
    bump(4'd15);
    check("R12 old above cmp", cause_o[15], 0);
    check("R10 final count", count_o, 19);
    check("R10 final cycles", cycles_o, 275);
    idle(3);
    check("R3 queue drained", expq.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule